// File: doc/BRIEF.md
# Conversion Result Serial Readout Formatter

This block sits between a converter's result path and its serial register port. Each time a new signed 24-bit result arrives, the block codes it. The coding is either two's complement or offset binary. The block can also clamp negative results to zero. The coded word is stored in a three-byte output register.

A host then asks for a multi-byte read from a start byte address, and the block shifts the bytes out one bit per clock. Two control bits set the order of the read:

- whether the byte address walks upward or downward;
- whether bits leave each byte most-significant or least-significant first.

A pin-select bit picks where read data goes out. One choice is the shared bidirectional data pin. The other is the dedicated output pin. The pin that is not chosen keeps its output enable low for the whole read.

The block copies the output register and the read controls when it accepts a read. A later conversion or a change to a control bit therefore cannot corrupt a read that is already under way. Each pin is shown as a data/enable pair, and the pad ring builds the tri-state drivers.

Top module: `crf_readout`

## Requirements
- R1: After reset the output register holds 000000 hex, `rd_busy` is low, and both output enables are low.
- R2: With `fmt_offset` low, results are stored as two's complement: +full-scale 7FFFFF, zero 000000, -full-scale 800000, and any other value unchanged.
- R3: With `fmt_offset` high, results are stored as offset binary. Bit 23 is inverted and bits 22..0 are unchanged, so +full-scale gives FFFFFF, zero gives 800000 and -full-scale gives 000000.
- R4: With `fmt_unipolar` high, a negative result is replaced by zero before coding, giving 000000 in two's complement or 800000 in offset binary. With it low there is no limit, and the very next conversion is stored as a normal bipolar value.
- R5: Byte address 0 holds register bits 23..16, address 1 holds bits 15..8, address 2 holds bits 7..0, and address 3 reads as 00. A read accepted with `rd_len` = L returns L+1 bytes. Each byte takes eight cycles, and one bit is presented per cycle, starting the cycle after `rd_start` is sampled. `rd_busy` is high for exactly 8(L+1) cycles.
- R6: With `rd_desc` low the byte address increments after each byte; with it high it decrements. Either way the address wraps modulo 4.
- R7: With `rd_lsb_first` low each byte is shifted out from bit 7 down to bit 0; with it high, from bit 0 up to bit 7.
- R8: With `rd_sep_pin` low, data goes out on `sdio_o` with `sdio_oe` high during the read, and `sdout_oe` and `sdout_o` stay low. With it high, the roles of the two pins are swapped. Outside a read both enables and both data outputs are low.
- R9: A read uses the register contents and the order and pin controls captured when it was accepted. Conversions, control changes and `rd_start` pulses that occur during the read do not change its bit stream or its length.
- R10: A result is stored on the clock edge where `conv_valid` is sampled high. A read accepted on that same edge still returns the previous contents, and any read accepted later returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | New conversion result present this cycle |
| conv_data | input | 24 | Signed two's complement conversion result |
| fmt_offset | input | 1 | 0: two's complement coding, 1: offset binary |
| fmt_unipolar | input | 1 | 1: clamp negative results to zero |
| rd_start | input | 1 | Request a read; accepted only while idle |
| rd_addr | input | 2 | Start byte address |
| rd_len | input | 2 | Number of bytes minus one |
| rd_desc | input | 1 | 0: ascending byte addresses, 1: descending |
| rd_lsb_first | input | 1 | 0: MSB first within a byte, 1: LSB first |
| rd_sep_pin | input | 1 | 0: shared bidirectional pin, 1: dedicated output pin |
| sdio_o | output | 1 | Read data toward the shared pin |
| sdio_oe | output | 1 | Output enable of the shared pin |
| sdout_o | output | 1 | Read data toward the dedicated pin |
| sdout_oe | output | 1 | Output enable of the dedicated pin |
| rd_busy | output | 1 | A read is in progress |

## Verification
A result written on a rising edge is visible only to reads accepted on a later edge. Once a read is accepted, its first bit is on the pins for the whole following cycle. Each further bit arrives one cycle later, and `rd_busy` falls 8(L+1) cycles after the accepting edge. The bench drives every input on falling edges and advances a queue-based reference model on rising edges. On every falling edge it compares all five outputs against the head of that queue, so each result is checked in the exact cycle it is due. Separate directed reads assemble the received bit stream and compare it with hand-derived constants for each coding, clamp, address walk and bit order.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic desc;
    logic lsb_first;
    logic sep_pin;
  } rd_cfg_t;
endpackage

// File: rtl/crf_format.sv
module crf_format #(
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_valid,
  input  logic [DW-1:0] conv_data,
  input  logic          fmt_offset,
  input  logic          fmt_unipolar,
  output logic [DW-1:0] word_q
);
  logic [DW-1:0] clamped;
  logic [DW-1:0] coded;
  logic [DW-1:0] word_d;

  always_comb begin
    clamped = (fmt_unipolar && conv_data[DW-1]) ? '0 : conv_data;
    coded   = {clamped[DW-1] ^ fmt_offset, clamped[DW-2:0]};
    word_d  = conv_valid ? coded : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  // R2: low bits pass through unchanged when no clamp applies
  a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid && !fmt_unipolar |=> word_q[DW-2:0] == $past(conv_data[DW-2:0]));

  // R3: top bit follows the coding choice
  a_r3_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid && !(fmt_unipolar && conv_data[DW-1])
    |=> word_q[DW-1] == ($past(conv_data[DW-1]) ^ $past(fmt_offset)));

  // R4: negative input under clamp becomes coded zero
  a_r4_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid && fmt_unipolar && conv_data[DW-1]
    |=> word_q[DW-2:0] == '0 && word_q[DW-1] == $past(fmt_offset));

  // R10: register only changes on a conversion
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_valid |=> $stable(word_q));
endmodule

// File: rtl/crf_serializer.sv
module crf_serializer
  import crf_pkg::*;
#(
  parameter int unsigned DW = 24,
  parameter int unsigned AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] word,
  input  logic          rd_start,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] rd_len,
  input  rd_cfg_t       cfg,
  output logic          busy,
  output logic          bit_o,
  output rd_cfg_t       cfg_q
);
  localparam int unsigned NB    = DW / BYTE_W;
  localparam int unsigned SLOTS = 1 << AW;
  localparam int unsigned CW    = $clog2(BYTE_W);

  logic          busy_q, busy_d;
  logic [DW-1:0] snap_q, snap_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [AW-1:0] left_q, left_d;
  logic [CW-1:0] bit_q, bit_d;
  rd_cfg_t       cfg_d;

  logic [BYTE_W-1:0] lane [SLOTS];
  logic [BYTE_W-1:0] cur_byte;
  logic [CW-1:0]     bit_idx;

  for (genvar g = 0; g < SLOTS; g++) begin : g_lane
    if (g < NB) begin : g_used
      assign lane[g] = snap_q[DW-1-g*BYTE_W -: BYTE_W];
    end else begin : g_empty
      assign lane[g] = '0;
    end
  end

  always_comb begin
    cur_byte = lane[ptr_q];
    bit_idx  = cfg_q.lsb_first ? bit_q : (CW'(BYTE_W-1) - bit_q);
    bit_o    = busy_q & cur_byte[bit_idx];
  end

  always_comb begin
    busy_d = busy_q;
    snap_d = snap_q;
    ptr_d  = ptr_q;
    left_d = left_q;
    bit_d  = bit_q;
    cfg_d  = cfg_q;
    if (!busy_q) begin
      if (rd_start) begin
        busy_d = 1'b1;
        snap_d = word;
        ptr_d  = rd_addr;
        left_d = rd_len;
        bit_d  = '0;
        cfg_d  = cfg;
      end
    end else if (bit_q == CW'(BYTE_W-1)) begin
      bit_d = '0;
      if (left_q == '0) begin
        busy_d = 1'b0;
      end else begin
        left_d = left_q - AW'(1);
        ptr_d  = cfg_q.desc ? ptr_q - AW'(1) : ptr_q + AW'(1);
      end
    end else begin
      bit_d = bit_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      snap_q <= '0;
      ptr_q  <= '0;
      left_q <= '0;
      bit_q  <= '0;
      cfg_q  <= '0;
    end else begin
      busy_q <= busy_d;
      snap_q <= snap_d;
      ptr_q  <= ptr_d;
      left_q <= left_d;
      bit_q  <= bit_d;
      cfg_q  <= cfg_d;
    end
  end

  assign busy = busy_q;

  // R9: captured word and controls do not move while a read runs
  a_r9_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(snap_q) && $stable(cfg_q));

  // R5: a read never ends in the middle of a byte
  a_r5_whole_byte: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && bit_q != CW'(BYTE_W-1) |=> busy_q);
endmodule

// File: rtl/crf_readout.sv
module crf_readout
  import crf_pkg::*;
#(
  parameter int unsigned DW = 24,
  parameter int unsigned AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_valid,
  input  logic [DW-1:0] conv_data,
  input  logic          fmt_offset,
  input  logic          fmt_unipolar,
  input  logic          rd_start,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] rd_len,
  input  logic          rd_desc,
  input  logic          rd_lsb_first,
  input  logic          rd_sep_pin,
  output logic          sdio_o,
  output logic          sdio_oe,
  output logic          sdout_o,
  output logic          sdout_oe,
  output logic          rd_busy
);
  logic [DW-1:0] word_q;
  logic          ser_bit;
  rd_cfg_t       cfg_in;
  rd_cfg_t       cfg_run;

  assign cfg_in = '{desc: rd_desc, lsb_first: rd_lsb_first, sep_pin: rd_sep_pin};

  crf_format #(.DW(DW)) u_format (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_valid   (conv_valid),
    .conv_data    (conv_data),
    .fmt_offset   (fmt_offset),
    .fmt_unipolar (fmt_unipolar),
    .word_q       (word_q)
  );

  crf_serializer #(.DW(DW), .AW(AW)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .word     (word_q),
    .rd_start (rd_start),
    .rd_addr  (rd_addr),
    .rd_len   (rd_len),
    .cfg      (cfg_in),
    .busy     (rd_busy),
    .bit_o    (ser_bit),
    .cfg_q    (cfg_run)
  );

  always_comb begin
    sdio_oe  = rd_busy & ~cfg_run.sep_pin;
    sdout_oe = rd_busy &  cfg_run.sep_pin;
    sdio_o   = sdio_oe  & ser_bit;
    sdout_o  = sdout_oe & ser_bit;
  end

  // R8: never both pins enabled
  a_r8_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sdio_oe, sdout_oe}));

  // R8: pins quiet while idle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_busy |-> !sdio_oe && !sdout_oe && !sdio_o && !sdout_o);
endmodule

// File: tb/tb_crf_readout.sv
module tb_crf_readout;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        conv_valid;
  logic [23:0] conv_data;
  logic        fmt_offset, fmt_unipolar;
  logic        rd_start;
  logic [1:0]  rd_addr, rd_len;
  logic        rd_desc, rd_lsb_first, rd_sep_pin;
  logic        sdio_o, sdio_oe, sdout_o, sdout_oe, rd_busy;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R5";

  always #4 clk = ~clk;

  crf_readout dut (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_data(conv_data),
    .fmt_offset(fmt_offset), .fmt_unipolar(fmt_unipolar), .rd_start(rd_start),
    .rd_addr(rd_addr), .rd_len(rd_len), .rd_desc(rd_desc),
    .rd_lsb_first(rd_lsb_first), .rd_sep_pin(rd_sep_pin), .sdio_o(sdio_o),
    .sdio_oe(sdio_oe), .sdout_o(sdout_o), .sdout_oe(sdout_oe), .rd_busy(rd_busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [23:0] m_reg;
  int          m_q[$];
  int          m_a;
  logic [7:0]  m_b;

  function automatic logic [23:0] m_code(logic [23:0] d, logic off, logic uni);
    logic [23:0] r;
    r = d;
    if (uni && $signed(d) < 0) r = 24'h0;
    if (off) r[23] = ~r[23];
    return r;
  endfunction

  function automatic logic [7:0] m_lane(logic [23:0] w, int a);
    case (a)
      0: return w[23:16];
      1: return w[15:8];
      2: return w[7:0];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 24'h0;
      m_q.delete();
    end else begin
      if (m_q.size() > 0) begin
        void'(m_q.pop_front());
      end else if (rd_start) begin
        m_a = int'(rd_addr);
        for (int n = 0; n <= int'(rd_len); n++) begin
          m_b = m_lane(m_reg, m_a);
          for (int k = 0; k < 8; k++)
            m_q.push_back(int'(rd_sep_pin) * 2 + int'(rd_lsb_first ? m_b[k] : m_b[7-k]));
          m_a = rd_desc ? (m_a + 3) % 4 : (m_a + 1) % 4;
        end
      end
      if (conv_valid) m_reg = m_code(conv_data, fmt_offset, fmt_unipolar);
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [4:0] exp_v;
      logic [4:0] got_v;
      got_v = {rd_busy, sdio_oe, sdio_o, sdout_oe, sdout_o};
      if (m_q.size() == 0) begin
        exp_v = 5'b0;
      end else begin
        logic sp, b;
        sp = m_q[0][1];
        b  = m_q[0][0];
        exp_v = {1'b1, !sp, !sp && b, sp, sp && b};
      end
      chk(got_v == exp_v, cur_req, 32'(got_v), 32'(exp_v));
    end
  end

  task automatic conv(input logic [23:0] d, input logic off, input logic uni);
    @(negedge clk);
    conv_data = d; fmt_offset = off; fmt_unipolar = uni; conv_valid = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  // returns the raw bit stream, first bit in the highest used position
  task automatic do_read(input logic [1:0] a, input logic [1:0] l, input logic d,
                         input logic lsb, input logic sp, output logic [31:0] raw);
    @(negedge clk);
    rd_addr = a; rd_len = l; rd_desc = d; rd_lsb_first = lsb; rd_sep_pin = sp;
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    raw = 32'h0;
    for (int i = 0; i < 8 * (int'(l) + 1); i++) begin
      raw = {raw[30:0], sp ? sdout_o : sdio_o};
      chk(!(sp ? sdio_oe : sdout_oe), "R8", 32'(sp ? sdio_oe : sdout_oe), 32'h0);
      @(negedge clk);
    end
    chk(!rd_busy, "R5", 32'(rd_busy), 32'h0);
  endtask

  logic [31:0] got;
  logic [23:0] vals [4];
  logic [23:0] expc [16];

  initial begin
    rst_n = 1'b0; conv_valid = 1'b0; conv_data = 24'h0; fmt_offset = 1'b0;
    fmt_unipolar = 1'b0; rd_start = 1'b0; rd_addr = 2'd0; rd_len = 2'd0;
    rd_desc = 1'b0; rd_lsb_first = 1'b0; rd_sep_pin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk({rd_busy, sdio_oe, sdout_oe} == 3'b0, "R1", 32'({rd_busy, sdio_oe, sdout_oe}), 32'h0);
    do_read(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, got);
    chk(got == 32'h0, "R1", got, 32'h0);

    // coding and clamp: index value*4 + offset*2 + unipolar
    vals[0] = 24'h7FFFFF; vals[1] = 24'h000000; vals[2] = 24'h800000; vals[3] = 24'hFFF000;
    expc[0]  = 24'h7FFFFF; expc[1]  = 24'h7FFFFF; expc[2]  = 24'hFFFFFF; expc[3]  = 24'hFFFFFF;
    expc[4]  = 24'h000000; expc[5]  = 24'h000000; expc[6]  = 24'h800000; expc[7]  = 24'h800000;
    expc[8]  = 24'h800000; expc[9]  = 24'h000000; expc[10] = 24'h000000; expc[11] = 24'h800000;
    expc[12] = 24'hFFF000; expc[13] = 24'h000000; expc[14] = 24'h7FF000; expc[15] = 24'h800000;
    for (int v = 0; v < 4; v++) begin
      for (int c = 0; c < 4; c++) begin
        string rq;
        rq = (c % 2 == 1) ? "R4" : ((c >= 2) ? "R3" : "R2");
        cur_req = rq;
        conv(vals[v], c[1], c[0]);
        do_read(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, got);
        chk(got[23:0] == expc[v*4+c], rq, got, 32'(expc[v*4+c]));
      end
    end

    // R4: clearing the clamp takes effect on the very next conversion
    cur_req = "R4";
    conv(24'h800001, 1'b0, 1'b1);
    do_read(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, got);
    chk(got == 32'h0, "R4", got, 32'h0);
    conv(24'h800001, 1'b0, 1'b0);
    do_read(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, got);
    chk(got == 32'h800001, "R4", got, 32'h800001);

    // R6 / R7: all byte and bit order combinations
    conv(24'hA1B2C3, 1'b0, 1'b0);
    cur_req = "R6";
    do_read(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, got);
    chk(got == 32'hA1B2C3, "R6", got, 32'hA1B2C3);
    cur_req = "R7";
    do_read(2'd0, 2'd2, 1'b0, 1'b1, 1'b0, got);
    chk(got == 32'h854DC3, "R7", got, 32'h854DC3);
    cur_req = "R6";
    do_read(2'd2, 2'd2, 1'b1, 1'b0, 1'b0, got);
    chk(got == 32'hC3B2A1, "R6", got, 32'hC3B2A1);
    cur_req = "R7";
    do_read(2'd2, 2'd2, 1'b1, 1'b1, 1'b0, got);
    chk(got == 32'hC34D85, "R7", got, 32'hC34D85);

    // R5 / R6: address 3 reads zero, wrap in both directions, single byte
    cur_req = "R5";
    do_read(2'd2, 2'd2, 1'b0, 1'b0, 1'b0, got);
    chk(got == 32'hC300A1, "R5", got, 32'hC300A1);
    do_read(2'd0, 2'd1, 1'b1, 1'b0, 1'b0, got);
    chk(got == 32'hA100, "R6", got, 32'hA100);
    do_read(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, got);
    chk(got == 32'hB2, "R5", got, 32'hB2);
    do_read(2'd3, 2'd3, 1'b0, 1'b0, 1'b0, got);
    chk(got == 32'h00A1B2C3, "R5", got, 32'h00A1B2C3);

    // R8: dedicated output pin
    cur_req = "R8";
    do_read(2'd0, 2'd2, 1'b0, 1'b0, 1'b1, got);
    chk(got == 32'hA1B2C3, "R8", got, 32'hA1B2C3);

    // R9: disturbances during a read are ignored
    cur_req = "R9";
    fork
      do_read(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, got);
      begin
        repeat (6) @(negedge clk);
        conv_data = 24'h123456; fmt_offset = 1'b0; fmt_unipolar = 1'b0; conv_valid = 1'b1;
        rd_start = 1'b1; rd_addr = 2'd2; rd_sep_pin = 1'b1; rd_desc = 1'b1; rd_lsb_first = 1'b1;
        @(negedge clk);
        conv_valid = 1'b0; rd_start = 1'b0; rd_sep_pin = 1'b0;
      end
    join
    chk(got == 32'hA1B2C3, "R9", got, 32'hA1B2C3);

    // R10: later read sees the new value
    cur_req = "R10";
    do_read(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, got);
    chk(got == 32'h123456, "R10", got, 32'h123456);

    // R10: same-edge conversion is not seen by that read
    fork
      conv(24'h0F0F0F, 1'b0, 1'b0);
      do_read(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, got);
    join
    chk(got == 32'h12, "R10", got, 32'h12);
    do_read(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, got);
    chk(got == 32'h0F, "R10", got, 32'h0F);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired got running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule